// File: doc/BRIEF.md
# Control Endpoint Status Handshake Unit

This block decides how the default control endpoint of a USB device answers each token that the serial interface engine reports. Every token gets one reply: ACK, NAK, STALL, or a data packet. The status stage of a control transfer is answered with NAK until firmware acts on it. Firmware either acknowledges the stage, which gives one ACK, or stalls it, which gives STALL until the next SETUP. The block also keeps the arming state of the endpoint 0 IN path. A byte count write arms the path, and the next data-stage IN token then gets a packet of that length. When the host accepts that packet, the path disarms and raises a one-cycle done pulse.

The engine presents one token per cycle. It marks the token as SETUP, IN or OUT, and uses a separate qualifier to flag a status-stage token. Firmware writes reach the block as single-cycle strobes. The set of strobes is: set-acknowledge, set-stall, byte count write and NAK-flag clear. The NAK-seen flag is sticky. It records every IN token that was answered with NAK, and it drives no interrupt.

There are two state machines. The status machine has three states:
- `SS_PEND`: the status stage is answered with NAK.
- `SS_ACK`: firmware has acknowledged, so the status stage is answered with ACK.
- `SS_STALL`: the transfer is stalled.

Its transitions are:
- ack-write: `SS_PEND`→`SS_ACK`.
- stall-write: any state→`SS_STALL`.
- status-consumed: `SS_ACK`→`SS_PEND` once the ACK has been given.
- setup-clear: any state→`SS_PEND`.
- bus-reset: any state→`SS_PEND`.

The IN machine also has three states:
- `IA_IDLE`: nothing to send.
- `IA_ARMED`: a packet is waiting.
- `IA_SENT`: the packet has gone out and awaits the host's ACK.

Its transitions are:
- count-write: any state→`IA_ARMED`.
- data-sent: `IA_ARMED`→`IA_SENT`.
- resend: `IA_SENT`→`IA_SENT` on a repeated IN token.
- host-accept: `IA_SENT`→`IA_IDLE`.
- setup-clear: any state→`IA_IDLE`.
- bus-reset: any state→`IA_IDLE`.

Top module: `ep0_hs_unit`

## Requirements
- R1: After reset, the outputs are all zero: `ack_flag`, `stall_flag`, `in_armed`, `nak_seen`, `bc_rd`, `hs_valid` and `in_done`.
- R2: A status-stage token (IN or OUT with `tok_status`=1) is answered NAK (`hs_code`=2) while neither the acknowledge flag nor the stall flag is set.
- R3: After an `ack_set` strobe, `ack_flag` reads 1 and the next status-stage token is answered ACK (`hs_code`=1).
- R4: Once a status-stage ACK has been given, `ack_flag` returns to 0, so the following status-stage token is answered NAK again.
- R5: After a `stall_set` strobe, `stall_flag` reads 1. Every IN or OUT token, status or data stage, is then answered STALL (`hs_code`=3) until the next SETUP.
- R6: A SETUP token is answered ACK. It clears the acknowledge and stall flags and disarms the IN path. A SETUP wins over an `ack_set` in the same cycle.
- R7: `bus_reset` clears the acknowledge flag, the stall flag, the arming, the byte count and the NAK-seen flag.
- R8: A byte count write arms the IN path. A data-stage IN token is answered with a data packet (`hs_code`=4) while armed, and with NAK when not armed.
- R9: A `host_ack` while a packet is outstanding disarms the IN path and gives a one-cycle `in_done` pulse.
- R10: Every IN token answered NAK sets `nak_seen`. `nak_clr` clears it, and a new NAK in the same cycle as the clear wins.
- R11: Bit 7 of the written byte count is ignored, and `bc_rd` bit 7 always reads 0.
- R12: A byte count above 64 is stored and read back as 64.
- R13: Each reply appears on `hs_valid`/`hs_code` in the cycle after its token. Code 0 is never presented with `hs_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power-on or chip reset) |
| bus_reset | input | 1 | Synchronous USB bus reset from the engine |
| tok_setup | input | 1 | SETUP token to endpoint 0 |
| tok_in | input | 1 | IN token to endpoint 0 |
| tok_out | input | 1 | OUT token to endpoint 0 |
| tok_status | input | 1 | Qualifies the IN/OUT token as the status stage |
| host_ack | input | 1 | Host acknowledged the IN data packet |
| ack_set | input | 1 | Firmware sets the acknowledge-status flag |
| stall_set | input | 1 | Firmware sets the stall flag |
| bc_wr | input | 1 | Firmware writes the byte count |
| bc_wdata | input | 8 | Byte count write data |
| nak_clr | input | 1 | Firmware writes 1 to clear the NAK-seen flag |
| hs_valid | output | 1 | Reply present this cycle |
| hs_code | output | 3 | Reply: 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| in_armed | output | 1 | IN path holds a packet to send |
| in_done | output | 1 | One-cycle pulse when the host accepted the packet |
| nak_seen | output | 1 | Sticky flag: an IN token was answered NAK |
| ack_flag | output | 1 | Acknowledge-status flag readback |
| stall_flag | output | 1 | Stall flag readback |
| bc_rd | output | 8 | Byte count readback and length of the packet to send |

## Verification
Suppose the status machine is left in the wrong state. This shows at the very next status-stage token: the code on `hs_code` one cycle later reads ACK where NAK was due, or the reverse. It also shows at once on `ack_flag` or `stall_flag`. A stale IN state shows as DATA or NAK on the next data-stage IN token, and as a missing or extra `in_done` pulse. A faulty count clamp or bit mask shows on `bc_rd` in the cycle after the write.

// File: rtl/ctl0_pkg.sv
package ctl0_pkg;

    typedef enum logic [2:0] {
        HS_NONE  = 3'd0,
        HS_ACK   = 3'd1,
        HS_NAK   = 3'd2,
        HS_STALL = 3'd3,
        HS_DATA  = 3'd4
    } hs_e;

    typedef enum logic [1:0] {
        SS_PEND  = 2'd0,
        SS_ACK   = 2'd1,
        SS_STALL = 2'd2
    } ss_e;

    typedef enum logic [1:0] {
        IA_IDLE  = 2'd0,
        IA_ARMED = 2'd1,
        IA_SENT  = 2'd2
    } ia_e;

endpackage

// File: rtl/ctl0_status_fsm.sv
module ctl0_status_fsm
    import ctl0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic tok_setup,
    input  logic status_tok,
    input  logic ack_set,
    input  logic stall_set,
    output logic ack_flag,
    output logic stall_flag
);

    ss_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (bus_reset || tok_setup) begin
            state_d = SS_PEND;
        end else if (stall_set) begin
            state_d = SS_STALL;
        end else begin
            unique case (state_q)
                SS_PEND:  if (ack_set) state_d = SS_ACK;
                SS_ACK:   if (status_tok && !ack_set) state_d = SS_PEND;
                SS_STALL: state_d = SS_STALL;
                default:  state_d = SS_PEND;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SS_PEND;
        else        state_q <= state_d;
    end

    always_comb begin
        ack_flag   = (state_q == SS_ACK);
        stall_flag = (state_q == SS_STALL);
    end

endmodule

// File: rtl/ctl0_in_arm.sv
module ctl0_in_arm
    import ctl0_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int REG_W   = 8,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             tok_setup,
    input  logic             data_in_tok,
    input  logic             host_ack,
    input  logic             bc_wr,
    input  logic [REG_W-1:0] bc_wdata,
    output logic             in_armed,
    output logic             in_done,
    output logic [CNT_W-1:0] bc_cnt
);

    localparam logic [REG_W-1:0] TOP_MASK = REG_W'(1) << (REG_W - 1);
    localparam logic [REG_W-1:0] LIMIT    = REG_W'(MAX_PKT);

    ia_e              state_q, state_d;
    logic [REG_W-1:0] masked;
    logic [CNT_W-1:0] cnt_d;
    logic             done_d;

    always_comb begin
        masked = bc_wdata & ~TOP_MASK;
        cnt_d  = (masked > LIMIT) ? CNT_W'(LIMIT) : CNT_W'(masked);
    end

    always_comb begin
        state_d = state_q;
        if (bus_reset || tok_setup) begin
            state_d = IA_IDLE;
        end else if (bc_wr) begin
            state_d = IA_ARMED;
        end else begin
            unique case (state_q)
                IA_IDLE:  state_d = IA_IDLE;
                IA_ARMED: if (data_in_tok) state_d = IA_SENT;
                IA_SENT:  if (host_ack) state_d = IA_IDLE;
                default:  state_d = IA_IDLE;
            endcase
        end
    end

    always_comb begin
        done_d = (state_q == IA_SENT) && host_ack && !bus_reset && !tok_setup;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IA_IDLE;
            in_done <= 1'b0;
            bc_cnt  <= '0;
        end else begin
            state_q <= state_d;
            in_done <= done_d;
            if (bus_reset)  bc_cnt <= '0;
            else if (bc_wr) bc_cnt <= cnt_d;
        end
    end

    always_comb in_armed = (state_q != IA_IDLE);

endmodule

// File: rtl/ctl0_reply.sv
module ctl0_reply
    import ctl0_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       tok_setup,
    input  logic       tok_in,
    input  logic       tok_out,
    input  logic       tok_status,
    input  logic       ack_flag,
    input  logic       stall_flag,
    input  logic       in_armed,
    input  logic       nak_clr,
    output logic       hs_valid,
    output logic [2:0] hs_code,
    output logic       nak_seen
);

    hs_e  code_d;
    logic any_tok;

    always_comb begin
        any_tok = tok_setup || tok_in || tok_out;
        code_d  = HS_NONE;
        if (tok_setup)          code_d = HS_ACK;
        else if (tok_in || tok_out) begin
            if (stall_flag)      code_d = HS_STALL;
            else if (tok_status) code_d = ack_flag ? HS_ACK : HS_NAK;
            else if (tok_in)     code_d = in_armed ? HS_DATA : HS_NAK;
            else                 code_d = HS_ACK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            nak_seen <= 1'b0;
        end else begin
            hs_valid <= any_tok && !bus_reset;
            hs_code  <= bus_reset ? HS_NONE : code_d;
            if (bus_reset)                                 nak_seen <= 1'b0;
            else if (tok_in && !tok_setup && code_d == HS_NAK) nak_seen <= 1'b1;
            else if (nak_clr)                              nak_seen <= 1'b0;
        end
    end

endmodule

// File: rtl/ep0_hs_unit.sv
module ep0_hs_unit
    import ctl0_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int REG_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             tok_setup,
    input  logic             tok_in,
    input  logic             tok_out,
    input  logic             tok_status,
    input  logic             host_ack,
    input  logic             ack_set,
    input  logic             stall_set,
    input  logic             bc_wr,
    input  logic [REG_W-1:0] bc_wdata,
    input  logic             nak_clr,
    output logic             hs_valid,
    output logic [2:0]       hs_code,
    output logic             in_armed,
    output logic             in_done,
    output logic             nak_seen,
    output logic             ack_flag,
    output logic             stall_flag,
    output logic [REG_W-1:0] bc_rd
);

    localparam int CNT_W = $clog2(MAX_PKT + 1);

    logic             status_tok;
    logic             data_in_tok;
    logic [CNT_W-1:0] bc_cnt;

    always_comb begin
        status_tok  = (tok_in || tok_out) && tok_status && !tok_setup;
        data_in_tok = tok_in && !tok_status && !tok_setup && !stall_flag && in_armed;
    end

    ctl0_status_fsm i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .tok_setup  (tok_setup),
        .status_tok (status_tok),
        .ack_set    (ack_set),
        .stall_set  (stall_set),
        .ack_flag   (ack_flag),
        .stall_flag (stall_flag)
    );

    ctl0_in_arm #(
        .MAX_PKT (MAX_PKT),
        .REG_W   (REG_W),
        .CNT_W   (CNT_W)
    ) i_in_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .tok_setup   (tok_setup),
        .data_in_tok (data_in_tok),
        .host_ack    (host_ack),
        .bc_wr       (bc_wr),
        .bc_wdata    (bc_wdata),
        .in_armed    (in_armed),
        .in_done     (in_done),
        .bc_cnt      (bc_cnt)
    );

    ctl0_reply i_reply (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_reset  (bus_reset),
        .tok_setup  (tok_setup),
        .tok_in     (tok_in),
        .tok_out    (tok_out),
        .tok_status (tok_status),
        .ack_flag   (ack_flag),
        .stall_flag (stall_flag),
        .in_armed   (in_armed),
        .nak_clr    (nak_clr),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code),
        .nak_seen   (nak_seen)
    );

    always_comb bc_rd = REG_W'(bc_cnt);

endmodule

// File: rtl/ep0_hs_unit_chk.sv
module ep0_hs_unit_chk
    import ctl0_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             tok_setup,
    input logic             tok_in,
    input logic             tok_out,
    input logic             tok_status,
    input logic             host_ack,
    input logic             ack_set,
    input logic             stall_set,
    input logic             bc_wr,
    input logic [REG_W-1:0] bc_wdata,
    input logic             nak_clr,
    input logic             hs_valid,
    input logic [2:0]       hs_code,
    input logic             in_armed,
    input logic             in_done,
    input logic             nak_seen,
    input logic             ack_flag,
    input logic             stall_flag,
    input logic [REG_W-1:0] bc_rd
);

    logic quiet;
    always_comb quiet = !bus_reset && !tok_setup && !stall_set;

    // R2
    status_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (tok_in || tok_out) && tok_status && !ack_flag && !stall_flag)
        |=> (hs_valid && hs_code == HS_NAK));

    // R3
    status_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && (tok_in || tok_out) && tok_status && ack_flag)
        |=> (hs_valid && hs_code == HS_ACK));

    // R4
    ack_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !ack_set && (tok_in || tok_out) && tok_status && ack_flag)
        |=> !ack_flag);

    // R6
    setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |=> (!ack_flag && !stall_flag && !in_armed));

    // R9
    done_after_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |-> $past(in_armed));

    // R10
    nak_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && tok_in && !tok_status && !in_armed && !stall_flag) |=> nak_seen);

    // R13
    valid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |-> (hs_code != HS_NONE));

endmodule

bind ep0_hs_unit ep0_hs_unit_chk #(.REG_W(REG_W)) i_chk (.*);

// File: tb/test_ep0_hs_unit.sv
module test_ep0_hs_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0, tok_setup = 1'b0, tok_in = 1'b0, tok_out = 1'b0;
    logic       tok_status = 1'b0, host_ack = 1'b0, ack_set = 1'b0, stall_set = 1'b0;
    logic       bc_wr = 1'b0, nak_clr = 1'b0;
    logic [7:0] bc_wdata = 8'd0;
    logic       hs_valid, in_armed, in_done, nak_seen, ack_flag, stall_flag;
    logic [2:0] hs_code;
    logic [7:0] bc_rd;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    localparam logic [2:0] C_ACK = 3'd1, C_NAK = 3'd2, C_STALL = 3'd3, C_DATA = 3'd4;

    always #10 clk = ~clk;

    ep0_hs_unit i_ep0_hs_unit (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected reply and compare against the design.
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R13: actual reply %0d expected none", hs_code);
            end else begin
                automatic logic [2:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (hs_code != e) begin
                    errors++;
                    $display("FAIL %s: actual %0d expected %0d", t, hs_code, e);
                end
            end
        end
    end

    // Driver: one token for one cycle, expected reply queued.
    task automatic tok(int kind, logic st, logic [2:0] e, string req);
        @(negedge clk);
        tok_setup  = (kind == 0);
        tok_in     = (kind == 1);
        tok_out    = (kind == 2);
        tok_status = st;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        tok_setup = 0; tok_in = 0; tok_out = 0; tok_status = 0;
    endtask

    task automatic strobe(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic write_bc(logic [7:0] v);
        @(negedge clk); bc_wr = 1'b1; bc_wdata = v;
        @(negedge clk); bc_wr = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ack_flag", ack_flag, 0);
        chk("R1 stall_flag", stall_flag, 0);
        chk("R1 in_armed", in_armed, 0);
        chk("R1 nak_seen", nak_seen, 0);
        chk("R1 bc_rd", bc_rd, 0);
        chk("R1 hs_valid", hs_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        tok(0, 0, C_ACK, "R6 setup reply");
        tok(2, 1, C_NAK, "R2 status out pending");
        tok(1, 1, C_NAK, "R2 status in pending");
        strobe(ack_set);
        chk("R3 ack_flag set", ack_flag, 1);
        tok(2, 1, C_ACK, "R3 status ack");
        chk("R4 ack_flag cleared", ack_flag, 0);
        tok(2, 1, C_NAK, "R4 next status nak");

        // R10 NAK-seen
        strobe(nak_clr);
        chk("R10 cleared", nak_seen, 0);
        tok(1, 0, C_NAK, "R8 in not armed");
        chk("R10 set by nak", nak_seen, 1);
        strobe(nak_clr);
        chk("R10 w1c", nak_seen, 0);
        @(negedge clk); nak_clr = 1; tok_in = 1;
        exp_q.push_back(C_NAK); tag_q.push_back("R8 in not armed 2");
        @(negedge clk); nak_clr = 0; tok_in = 0;
        chk("R10 set wins over clear", nak_seen, 1);

        // R11 R8 R9
        write_bc(8'h85);
        chk("R11 bit7 ignored", bc_rd, 5);
        chk("R8 armed", in_armed, 1);
        tok(2, 0, C_ACK, "R8 data out ack");
        tok(1, 0, C_DATA, "R8 data in");
        tok(1, 0, C_DATA, "R8 resend");
        strobe(host_ack);
        chk("R9 in_done pulse", in_done, 1);
        chk("R9 disarmed", in_armed, 0);
        @(negedge clk);
        chk("R9 pulse one cycle", in_done, 0);
        tok(1, 0, C_NAK, "R8 after disarm");

        // R12 clamp
        write_bc(8'h50);
        chk("R12 clamp 80", bc_rd, 64);
        write_bc(8'h40);
        chk("R12 exact 64", bc_rd, 64);
        write_bc(8'hFF);
        chk("R12 clamp 127", bc_rd, 64);
        chk("R11 bit7 reads 0", bc_rd[7], 0);
        write_bc(8'h00);
        chk("R8 zero length arms", in_armed, 1);

        // R5 stall
        strobe(stall_set);
        chk("R5 stall_flag", stall_flag, 1);
        tok(1, 1, C_STALL, "R5 status in");
        tok(1, 0, C_STALL, "R5 data in");
        tok(2, 0, C_STALL, "R5 data out");
        strobe(ack_set);
        tok(2, 1, C_STALL, "R5 ack does not override");
        tok(0, 0, C_ACK, "R6 setup reply");
        chk("R6 stall cleared", stall_flag, 0);
        chk("R6 disarmed", in_armed, 0);
        strobe(ack_set);
        tok(0, 0, C_ACK, "R6 setup reply");
        chk("R6 ack cleared", ack_flag, 0);
        @(negedge clk); ack_set = 1; tok_setup = 1;
        exp_q.push_back(C_ACK); tag_q.push_back("R6 setup reply");
        @(negedge clk); ack_set = 0; tok_setup = 0;
        chk("R6 setup beats ack", ack_flag, 0);

        // R7 bus reset
        strobe(ack_set);
        write_bc(8'd10);
        tok(1, 1, C_ACK, "R3 status in ack");
        strobe(ack_set);
        tok(1, 0, C_DATA, "R8 data in");
        write_bc(8'd12);
        @(negedge clk); tok_in = 1; tok_status = 1; stall_set = 0;
        exp_q.push_back(C_ACK); tag_q.push_back("R3 status in ack 2");
        @(negedge clk); tok_in = 0; tok_status = 0;
        strobe(ack_set);
        @(negedge clk); nak_clr = 1; @(negedge clk); nak_clr = 0;
        @(negedge clk); tok_in = 1; tok_status = 0;
        exp_q.push_back(C_DATA); tag_q.push_back("R8 data in 2");
        @(negedge clk); tok_in = 0;
        strobe(bus_reset);
        chk("R7 ack_flag", ack_flag, 0);
        chk("R7 in_armed", in_armed, 0);
        chk("R7 bc_rd", bc_rd, 0);
        chk("R7 stall_flag", stall_flag, 0);
        tok(1, 0, C_NAK, "R7 in after reset");
        strobe(bus_reset);
        chk("R7 nak_seen", nak_seen, 0);

        repeat (3) @(negedge clk);
        chk("R13 all replies seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule